// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block sits next to a simple CPU sequencer and decides when exception handling begins and which pending cause wins. Four causes compete: a reset, a trace step, a maskable interrupt and a trap instruction. They rank in that order, highest first. Reset comes from the rising edge of an external reset pin, passed through a synchroniser, or from a watchdog overflow strobe. The trace and interrupt causes are sampled only at instruction or handling-sequence boundaries, and certain boundaries suppress them. A trap is taken as soon as the sequencer reports it and the controller is free. A trap that cannot be taken at once is held until it can.

When the controller accepts a cause, it raises a one-clock accept pulse together with a 2-bit type code and a vector table index. The sequencer uses the index to fetch the handler start address. A busy flag stays high from the acceptance until the sequencer signals the end of the handling sequence. While the synchronised reset pin is low, the busy flag is also forced high and nothing is accepted.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several causes are eligible in the same cycle, only the highest ranked one is accepted. The ranking from highest to lowest is reset, trace, interrupt, trap. A lower cause is taken at a later eligible point if it is still requested.
- R2: A reset is accepted with type code 2'b00 and vector 0. It is accepted even while busy. A rising edge on `res_pin` is seen through a two-flop synchroniser plus an edge register, so acceptance shows at the third rising clock edge after the pin goes high. A `wdt_ovf` strobe shows at the first edge. Reset acceptance discards any held trap.
- R3: After block reset, `busy` is 1 and `accept` is 0. While the synchronised pin is low, `busy` is held at 1, no cause is accepted (a watchdog strobe included) and any held trap is discarded.
- R4: Trace and interrupt are considered only at a boundary. When idle, the boundary is `insn_end`. When busy, it is `seq_end`. An `insn_end` while busy has no effect.
- R5: Trace requires `trace_en` = 1 and `ctl_mode` = 2'b10. It is not taken at an `insn_end` flagged by `insn_is_rte`.
- R6: An interrupt is accepted with type code 2'b10 and vector `irq_vec`. It is not taken at an `insn_end` flagged by `insn_is_ccr_mod`. It is not taken at the `seq_end` that closes a reset handling sequence.
- R7: A trap (`trap_exec`) is accepted with type code 2'b11 and vector 8 + `trap_num`. It is taken while idle or at a `seq_end`. Otherwise it is held with its number until it is taken.
- R8: `accept` is a registered one-clock pulse, issued at the edge after the deciding cycle. `busy` rises with it and falls at a `seq_end` that brings no new acceptance. While busy, only reset or a cause at `seq_end` can be accepted.
- R9: Trace is accepted with type code 2'b01 and vector 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| res_pin | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| trace_en | input | 1 | Trace enable bit |
| ctl_mode | input | 2 | Interrupt control mode; 2'b10 allows trace |
| irq_req | input | 1 | Pending maskable interrupt |
| irq_vec | input | VEC_W | Vector number for the interrupt |
| trap_exec | input | 1 | Trap instruction executed strobe |
| trap_num | input | 2 | Trap number |
| insn_end | input | 1 | Instruction boundary strobe |
| seq_end | input | 1 | Handling sequence end strobe |
| insn_is_rte | input | 1 | Ending instruction is a return from exception |
| insn_is_ccr_mod | input | 1 | Ending instruction modifies the control register |
| accept | output | 1 | One-clock acceptance pulse |
| exc_type | output | 2 | Accepted cause type code |
| vec_idx | output | VEC_W | Vector table index |
| busy | output | 1 | Handling sequence in progress or pin held low |

## Verification
Each decision is made from the inputs present in one cycle. `accept`, `exc_type`, `vec_idx` and `busy` change at the next rising edge. The one exception is a rise on the reset pin, which takes three edges to reach the outputs. The bench drives inputs on the falling edge and advances its own cycle model in the same half-period. It compares the outputs at the following falling edge, which is exactly one clock after the stimulus, so the pin-rise delay falls out of the model's own three-stage history. Type code and vector are compared only in cycles where an acceptance is expected or seen, because they hold their last value otherwise.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    EXC_RESET = 2'b00,
    EXC_TRACE = 2'b01,
    EXC_IRQ   = 2'b10,
    EXC_TRAP  = 2'b11
  } exc_kind_e;

  localparam int          RESET_VEC     = 0;
  localparam int          TRACE_VEC     = 5;
  localparam int          TRAP_VEC_BASE = 8;
  localparam logic [1:0]  TRACE_MODE    = 2'b10;
endpackage

// File: rtl/exc_res_sync.sv
module exc_res_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_low,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= pin;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign pin_low = !chain[STAGES-1];
  assign rise    = chain[STAGES-1] && !last_q;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             pin_low,
  input  logic             reset_req,
  input  logic             busy,
  input  logic             cur_reset,
  input  logic             insn_end,
  input  logic             seq_end,
  input  logic             trace_en,
  input  logic [1:0]       ctl_mode,
  input  logic             insn_is_rte,
  input  logic             insn_is_ccr_mod,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             trap_cand,
  input  logic [1:0]       trap_no,
  output logic             take,
  output exc_kind_e        kind,
  output logic [VEC_W-1:0] vec
);
  function automatic logic [VEC_W-1:0] vector_of(exc_kind_e k, logic [1:0] tn,
                                                 logic [VEC_W-1:0] iv);
    case (k)
      EXC_RESET: return VEC_W'(RESET_VEC);
      EXC_TRACE: return VEC_W'(TRACE_VEC);
      EXC_IRQ:   return iv;
      default:   return VEC_W'(TRAP_VEC_BASE) + VEC_W'(tn);
    endcase
  endfunction

  logic open_w, boundary_w, trace_ok, irq_ok, trap_ok;

  always_comb begin
    open_w     = !busy || seq_end;
    boundary_w = busy ? seq_end : insn_end;
    trace_ok   = boundary_w && trace_en && (ctl_mode == TRACE_MODE)
                 && !(!busy && insn_is_rte);
    irq_ok     = boundary_w && irq_req && !(!busy && insn_is_ccr_mod)
                 && !(busy && cur_reset);
    trap_ok    = open_w && trap_cand;

    take = 1'b0;
    kind = EXC_RESET;
    if (!pin_low) begin
      if (reset_req)     begin take = 1'b1; kind = EXC_RESET; end
      else if (trace_ok) begin take = 1'b1; kind = EXC_TRACE; end
      else if (irq_ok)   begin take = 1'b1; kind = EXC_IRQ;   end
      else if (trap_ok)  begin take = 1'b1; kind = EXC_TRAP;  end
    end
    vec = vector_of(kind, trap_no, irq_vec);
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_pin,
  input  logic             wdt_ovf,
  input  logic             trace_en,
  input  logic [1:0]       ctl_mode,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             trap_exec,
  input  logic [1:0]       trap_num,
  input  logic             insn_end,
  input  logic             seq_end,
  input  logic             insn_is_rte,
  input  logic             insn_is_ccr_mod,
  output logic             accept,
  output logic [1:0]       exc_type,
  output logic [VEC_W-1:0] vec_idx,
  output logic             busy
);
  logic             pin_low_w, rise_w, reset_req_w;
  logic             take_w, trap_cand_w, trap_taken_w;
  exc_kind_e        take_kind_w, kind_q;
  logic [VEC_W-1:0] take_vec_w;
  logic             trap_pend_q, cur_reset_q;
  logic [1:0]       trap_no_q, trap_sel_w;

  exc_res_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (res_pin),
    .pin_low (pin_low_w),
    .rise    (rise_w)
  );

  assign reset_req_w = rise_w || wdt_ovf;
  assign trap_cand_w = trap_exec || trap_pend_q;
  assign trap_sel_w  = trap_pend_q ? trap_no_q : trap_num;

  exc_arbiter #(.VEC_W(VEC_W)) u_arb (
    .pin_low         (pin_low_w),
    .reset_req       (reset_req_w),
    .busy            (busy),
    .cur_reset       (cur_reset_q),
    .insn_end        (insn_end),
    .seq_end         (seq_end),
    .trace_en        (trace_en),
    .ctl_mode        (ctl_mode),
    .insn_is_rte     (insn_is_rte),
    .insn_is_ccr_mod (insn_is_ccr_mod),
    .irq_req         (irq_req),
    .irq_vec         (irq_vec),
    .trap_cand       (trap_cand_w),
    .trap_no         (trap_sel_w),
    .take            (take_w),
    .kind            (take_kind_w),
    .vec             (take_vec_w)
  );

  assign trap_taken_w = take_w && (take_kind_w == EXC_TRAP);

  // Output stage and handling-sequence state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept      <= 1'b0;
      kind_q      <= EXC_RESET;
      vec_idx     <= '0;
      busy        <= 1'b1;
      cur_reset_q <= 1'b0;
    end else begin
      accept <= take_w;
      if (take_w) begin
        kind_q      <= take_kind_w;
        vec_idx     <= take_vec_w;
        cur_reset_q <= (take_kind_w == EXC_RESET);
      end
      if (pin_low_w || take_w) busy <= 1'b1;
      else if (seq_end)        busy <= 1'b0;
    end
  end

  // Held trap request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_pend_q <= 1'b0;
      trap_no_q   <= 2'b00;
    end else begin
      if (pin_low_w || reset_req_w) trap_pend_q <= 1'b0;
      else                          trap_pend_q <= trap_cand_w && !trap_taken_w;
      if (trap_exec && !trap_pend_q) trap_no_q <= trap_num;
    end
  end

  assign exc_type = kind_q;
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pin_low_w,
  input logic             trace_en,
  input logic [1:0]       ctl_mode,
  input logic             insn_end,
  input logic             insn_is_ccr_mod,
  input logic             seq_end,
  input logic             busy,
  input logic             accept,
  input logic [1:0]       exc_type,
  input logic [VEC_W-1:0] vec_idx
);
  assert_pinlow_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_low_w |=> (!accept && busy));

  assert_busy_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && $past(busy) && !$past(seq_end)) |-> (exc_type == 2'b00));

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> busy);

  assert_trace_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc_type == 2'b01) |-> ($past(trace_en) && $past(ctl_mode) == 2'b10));

  assert_irq_ccr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc_type == 2'b10)
      |-> !($past(insn_end) && !$past(busy) && $past(insn_is_ccr_mod)));

  assert_reset_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc_type == 2'b00) |-> (vec_idx == '0));

  assert_trace_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc_type == 2'b01) |-> (vec_idx == VEC_W'(5)));

  assert_trap_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc_type == 2'b11) |-> (vec_idx >= VEC_W'(8) && vec_idx <= VEC_W'(11)));
endmodule

bind exc_entry_ctrl exc_entry_checker #(.VEC_W(VEC_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .pin_low_w       (pin_low_w),
  .trace_en        (trace_en),
  .ctl_mode        (ctl_mode),
  .insn_end        (insn_end),
  .insn_is_ccr_mod (insn_is_ccr_mod),
  .seq_end         (seq_end),
  .busy            (busy),
  .accept          (accept),
  .exc_type        (exc_type),
  .vec_idx         (vec_idx)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_pin, wdt_ovf, trace_en, irq_req, trap_exec;
  logic insn_end, seq_end, insn_is_rte, insn_is_ccr_mod;
  logic [1:0] ctl_mode, trap_num;
  logic [VW-1:0] irq_vec;
  logic accept, busy;
  logic [1:0] exc_type;
  logic [VW-1:0] vec_idx;

  always #2 clk = ~clk;

  exc_entry_ctrl #(.VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .res_pin(res_pin), .wdt_ovf(wdt_ovf),
    .trace_en(trace_en), .ctl_mode(ctl_mode), .irq_req(irq_req), .irq_vec(irq_vec),
    .trap_exec(trap_exec), .trap_num(trap_num), .insn_end(insn_end), .seq_end(seq_end),
    .insn_is_rte(insn_is_rte), .insn_is_ccr_mod(insn_is_ccr_mod),
    .accept(accept), .exc_type(exc_type), .vec_idx(vec_idx), .busy(busy)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  string tag   = "";

  // Bench model state: pin history, sequence state, held trap
  logic [2:0] pin_hist = 3'b000;   // [0] first flop, [1] second flop, [2] edge register
  logic m_busy = 1'b1, m_pend = 1'b0, m_after_rst = 1'b0;
  logic [1:0] m_pnum = 2'b00;
  logic e_acc = 1'b0, e_busy = 1'b1;
  int   e_type = 0, e_vec = 0;

  function automatic int trap_vector(logic [1:0] n);
    return 8 + int'(n);
  endfunction

  task automatic model_step();
    logic synced, edge_seen, boundary, can_trace, can_irq, can_trap, trap_pending;
    int pick;
    synced    = pin_hist[1];
    edge_seen = pin_hist[1] && !pin_hist[2];
    pin_hist  = {pin_hist[1], pin_hist[0], res_pin};
    pick = -1;
    if (!synced) begin
      e_acc = 1'b0; m_busy = 1'b1; m_pend = 1'b0;
    end else if (edge_seen || wdt_ovf) begin
      pick = 0; m_pend = 1'b0;
    end else begin
      boundary     = m_busy ? seq_end : insn_end;
      trap_pending = m_pend || trap_exec;
      can_trace = boundary && trace_en && ctl_mode == 2'b10 && !(!m_busy && insn_is_rte);
      can_irq   = boundary && irq_req && !(!m_busy && insn_is_ccr_mod) && !(m_busy && m_after_rst);
      can_trap  = trap_pending && (!m_busy || seq_end);
      if (can_trace)     pick = 1;
      else if (can_irq)  pick = 2;
      else if (can_trap) pick = 3;
      if (trap_exec && !m_pend) m_pnum = trap_num;
      m_pend = trap_pending && (pick != 3);
      if (pick < 0 && seq_end) m_busy = 1'b0;
    end
    e_acc = (pick >= 0);
    if (pick >= 0) begin
      e_type = pick;
      case (pick)
        0: e_vec = 0;
        1: e_vec = 5;
        2: e_vec = int'(irq_vec);
        default: e_vec = trap_vector(m_pnum);
      endcase
      m_busy = 1'b1;
      m_after_rst = (pick == 0);
    end
    e_busy = m_busy;
  endtask

  function automatic string auto_tag(logic a, int t);
    if (!a) return "R8";
    case (t)
      0: return "R2";
      1: return "R9";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    string r;
    logic bad;
    n_checks++;
    bad = (accept !== e_acc) || (busy !== e_busy) ||
          (e_acc && (int'(exc_type) != e_type || int'(vec_idx) != e_vec));
    if (bad) begin
      n_fails++;
      r = (tag != "") ? tag : auto_tag(e_acc | accept, e_acc ? e_type : int'(exc_type));
      $display("FAIL %s cyc=%0d acc=%b/%b busy=%b/%b type=%0d/%0d vec=%0d/%0d (actual/expected)",
               r, cyc, accept, e_acc, busy, e_busy, exc_type, e_type, vec_idx, e_vec);
    end
  endtask

  task automatic quiet();
    wdt_ovf = 0; trace_en = 0; ctl_mode = 2'b00; irq_req = 0; irq_vec = 8'h40;
    trap_exec = 0; trap_num = 0; insn_end = 0; seq_end = 0;
    insn_is_rte = 0; insn_is_ccr_mod = 0;
  endtask

  task automatic step(string t);
    tag = t;
    model_step();
    @(negedge clk);
    compare();
    quiet();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    res_pin = 1'b1;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R3"; compare();                  // reset state: busy 1, accept 0
    step("R2"); step("R2"); step("R2");      // third edge after pin high: reset accept
    // R6: no interrupt at the end of the reset sequence
    irq_req = 1; irq_vec = 8'h33; seq_end = 1; step("R6");
    irq_req = 1; irq_vec = 8'h33; insn_end = 1; insn_is_ccr_mod = 1; step("R6");
    irq_req = 1; irq_vec = 8'h33; insn_end = 1; step("R6");
    seq_end = 1; step("R8");
    // R1: trace beats interrupt and trap; the others follow at sequence ends
    trace_en = 1; ctl_mode = 2'b10; irq_req = 1; irq_vec = 8'h21;
    trap_exec = 1; trap_num = 2'd3; insn_end = 1; step("R1");
    irq_req = 1; irq_vec = 8'h21; insn_end = 1; step("R4");
    irq_req = 1; irq_vec = 8'h21; seq_end = 1; step("R1");
    seq_end = 1; step("R7");
    seq_end = 1; step("R8");
    // R5: trace gating
    trace_en = 1; ctl_mode = 2'b00; insn_end = 1; step("R5");
    trace_en = 1; ctl_mode = 2'b10; insn_end = 1; insn_is_rte = 1; step("R5");
    trace_en = 1; ctl_mode = 2'b10; insn_end = 1; step("R9");
    trace_en = 1; ctl_mode = 2'b10; seq_end = 1; step("R4");
    seq_end = 1; step("R8");
    // R2: watchdog while busy
    trap_exec = 1; trap_num = 2'd1; step("R7");
    wdt_ovf = 1; step("R2");
    seq_end = 1; step("R8");
    // R3: pin low discards a held trap
    trap_exec = 1; trap_num = 2'd2; step("R7");
    trap_exec = 1; trap_num = 2'd0; step("R7");
    res_pin = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i == 3) wdt_ovf = 1;
      step("R3");
    end
    res_pin = 1'b1;
    for (int i = 0; i < 3; i++) step("R2");
    seq_end = 1; step("R3");
    for (int i = 0; i < 3; i++) step("R3");

    // Constrained random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 400) == 0) res_pin = 1'b0;
      else if (!res_pin && ($urandom % 4) == 0) res_pin = 1'b1;
      wdt_ovf         = ($urandom % 150) == 0;
      trace_en        = ($urandom % 5) == 0;
      ctl_mode        = 2'($urandom);
      irq_req         = ($urandom % 3) == 0;
      irq_vec         = 8'($urandom % 200 + 16);
      insn_is_rte     = ($urandom % 4) == 0;
      insn_is_ccr_mod = ($urandom % 4) == 0;
      insn_end        = !m_busy && ($urandom % 2) == 0;
      seq_end         = m_busy && ($urandom % 3) == 0;
      trap_exec       = !m_busy && !m_pend && ($urandom % 10) == 0;
      trap_num        = 2'($urandom);
      step("");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule